// File: doc/BRIEF.md
# Banked Breakpoint Comparator Register Window

This block is the software-facing register file of a hardware breakpoint unit that has four comparators, numbered 0 to 3. The comparators have different amounts of storage. Comparators 0 and 2 are full-width: each holds a control byte, a 24-bit address, a 16-bit data value and a 16-bit data mask. Comparators 1 and 3 are address-only: each holds just a control byte and a 24-bit address. All four share one 8-byte window in the byte address space. A 2-bit bank-select input, driven from a separate control register, chooses which comparator's registers appear in that window.

The block decodes byte-wide reads and writes that fall inside the window and steers each one to the selected comparator's physical register. Writes are refused while the debug unit is armed. Reads are always served, and each read returns a mask of the bits that have no storage behind them. The stored values are driven out in parallel so that the matching logic, which lives elsewhere, can use them.

Top module: `dbg_cmp_window`

## Requirements
- R1: After reset every control, address, data and mask register holds 0x00, and `rdata` and `rd_void` are 0x00.
- R2: An access whose address lies outside 0x0028..0x002F changes no register, and a read there returns `rdata`=0x00 with `rd_void`=0xFF.
- R3: The bank select is decoded as follows: 0 selects comparator 0, 1 selects comparator 1, 2 selects comparator 2 and 3 selects comparator 3. A write reaches only the comparator that is selected.
- R4: The window offsets, counted from 0x28, map as follows:
  - offset 0 is the control byte;
  - offsets 1, 2 and 3 are the address high, middle and low bytes;
  - offsets 4 and 5 are the data high and low bytes;
  - offsets 6 and 7 are the mask high and low bytes.
- R5: On comparators 0 and 2, control bit 7 is never stored, always reads 0, and is reported in `rd_void` as 0x80. On comparators 1 and 3, all 8 control bits are stored.
- R6: On comparators 1 and 3, offsets 4 to 7 read 0x00 with `rd_void`=0xFF, and writes to those offsets are dropped.
- R7: A write is dropped when `armed` is 1 in the same clock cycle as the write strobe, and every register keeps its contents.
- R8: Reads return the stored contents while `armed` is 1.
- R9: Read data and `rd_void` are registered. They appear in the cycle after `rd_en`, and they are 0x00 in any cycle that follows a cycle without `rd_en`.
- R10: A read and a write to the same register in the same cycle return the old contents. The new value is returned by the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| armed | input | 1 | Debug unit armed; blocks writes |
| bank_sel | input | 2 | Comparator visible in the window |
| rd_en | input | 1 | Byte read strobe |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 16 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rd_void | output | 8 | Registered mask of unimplemented bits for the read |
| ctl_q | output | 32 | Control bytes, comparator n at [8n+7:8n] |
| addr_q | output | 96 | Addresses, comparator n at [24n+23:24n] |
| data_q | output | 64 | Data values, comparator n at [16n+15:16n] |
| mask_q | output | 64 | Data masks, comparator n at [16n+15:16n] |

## Verification
Two events can fall in the same cycle: a read of a register and a write to that same register. The bench raises both strobes on one edge at one offset, with write data that differs from the stored byte. It expects the registered read to return the old byte and a following read to return the new one. The arm flag is also raised on the same edge as a write strobe. The bench then confirms, by reading back while armed, that the stored byte did not change.

// File: rtl/dbg_win_pkg.sv
package dbg_win_pkg;

   // Window slot indices (byte offset inside the 8-byte window)
   localparam int SLOT_CTL  = 0;
   localparam int SLOT_ADDR = 1;

   // Mask with only the top bit of a byte-wide field set
   function automatic logic [7:0] top_bit_mask();
      return 8'h80;
   endfunction

endpackage

// File: rtl/dbg_win_decode.sv
module dbg_win_decode #(
   parameter int          ADDR_W   = 16,
   parameter logic [15:0] WIN_BASE = 16'h0028,
   parameter int          N_BANK   = 4,
   parameter int          SEL_W    = 2,
   parameter int          SLOT_W   = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SEL_W-1:0]  bank_sel,
   input  logic              wr_en,
   input  logic              armed,
   output logic              hit,
   output logic [SLOT_W-1:0] slot,
   output logic [N_BANK-1:0] wr_sel
);
   localparam logic [ADDR_W-1:0] BASE_N = ADDR_W'(WIN_BASE);

   logic wr_ok;

   assign hit   = (addr >> SLOT_W) == (BASE_N >> SLOT_W);
   assign slot  = addr[SLOT_W-1:0];
   assign wr_ok = wr_en & hit & ~armed;

   for (genvar b = 0; b < N_BANK; b++) begin : g_sel
      assign wr_sel[b] = wr_ok & (bank_sel == SEL_W'(b));
   end
endmodule

// File: rtl/dbg_win_bank.sv
module dbg_win_bank #(
   parameter bit FULL       = 1'b1,
   parameter int DW         = 8,
   parameter int ADDR_BYTES = 3,
   parameter int DATA_BYTES = 2,
   parameter int SLOT_W     = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [SLOT_W-1:0]          slot,
   input  logic [DW-1:0]              wdata,
   output logic [DW-1:0]              rd_byte,
   output logic [DW-1:0]              ctl_o,
   output logic [ADDR_BYTES*DW-1:0]   addr_o,
   output logic [DATA_BYTES*DW-1:0]   data_o,
   output logic [DATA_BYTES*DW-1:0]   mask_o
);
   import dbg_win_pkg::*;

   localparam int DATA_SLOT = SLOT_ADDR + ADDR_BYTES;
   localparam int MASK_SLOT = DATA_SLOT + DATA_BYTES;
   localparam logic [DW-1:0] CTL_IMPL =
      FULL ? ~DW'(top_bit_mask()) : {DW{1'b1}};

   logic [DW-1:0] ctl_r;
   logic [DW-1:0] addr_r [ADDR_BYTES];
   logic [DW-1:0] data_rd, mask_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    ctl_r <= '0;
      else if (we && slot == SLOT_W'(SLOT_CTL))      ctl_r <= wdata & CTL_IMPL;
   end
   assign ctl_o = ctl_r;

   for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_addr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                      addr_r[i] <= '0;
         else if (we && slot == SLOT_W'(SLOT_ADDR + i))   addr_r[i] <= wdata;
      end
      assign addr_o[(ADDR_BYTES-1-i)*DW +: DW] = addr_r[i];
   end

   if (FULL) begin : g_full
      logic [DW-1:0] data_r [DATA_BYTES];
      logic [DW-1:0] mask_r [DATA_BYTES];
      for (genvar i = 0; i < DATA_BYTES; i++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_r[i] <= '0;
               mask_r[i] <= '0;
            end else if (we) begin
               if (slot == SLOT_W'(DATA_SLOT + i)) data_r[i] <= wdata;
               if (slot == SLOT_W'(MASK_SLOT + i)) mask_r[i] <= wdata;
            end
         end
         assign data_o[(DATA_BYTES-1-i)*DW +: DW] = data_r[i];
         assign mask_o[(DATA_BYTES-1-i)*DW +: DW] = mask_r[i];
      end
      always_comb begin
         data_rd = '0;
         mask_rd = '0;
         for (int i = 0; i < DATA_BYTES; i++) begin
            if (slot == SLOT_W'(DATA_SLOT + i)) data_rd = data_r[i];
            if (slot == SLOT_W'(MASK_SLOT + i)) mask_rd = mask_r[i];
         end
      end
   end else begin : g_short
      assign data_o  = '0;
      assign mask_o  = '0;
      assign data_rd = '0;
      assign mask_rd = '0;
   end

   always_comb begin
      rd_byte = data_rd | mask_rd;
      if (slot == SLOT_W'(SLOT_CTL)) rd_byte = ctl_r;
      for (int i = 0; i < ADDR_BYTES; i++)
         if (slot == SLOT_W'(SLOT_ADDR + i)) rd_byte = addr_r[i];
   end
endmodule

// File: rtl/dbg_win_rdport.sv
module dbg_win_rdport #(
   parameter int               DW         = 8,
   parameter int               N_BANK     = 4,
   parameter int               SEL_W      = 2,
   parameter int               SLOT_W     = 3,
   parameter int               ADDR_BYTES = 3,
   parameter logic [N_BANK-1:0] FULL_MASK = 4'b0101
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_en,
   input  logic                 hit,
   input  logic [SEL_W-1:0]     bank_sel,
   input  logic [SLOT_W-1:0]    slot,
   input  logic [N_BANK*DW-1:0] bank_bytes,
   output logic [DW-1:0]        rdata,
   output logic [DW-1:0]        rd_void
);
   import dbg_win_pkg::*;

   logic          sel_full;
   logic [DW-1:0] void_n, data_n;

   assign sel_full = FULL_MASK[bank_sel];

   always_comb begin
      data_n = hit ? bank_bytes[bank_sel*DW +: DW] : '0;
      void_n = '0;
      if (!hit)
         void_n = '1;
      else if (sel_full && slot == SLOT_W'(SLOT_CTL))
         void_n = DW'(top_bit_mask());
      else if (!sel_full && slot >= SLOT_W'(SLOT_ADDR + ADDR_BYTES))
         void_n = '1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata   <= '0;
         rd_void <= '0;
      end else if (rd_en) begin
         rdata   <= data_n;
         rd_void <= void_n;
      end else begin
         rdata   <= '0;
         rd_void <= '0;
      end
   end
endmodule

// File: rtl/dbg_cmp_window.sv
module dbg_cmp_window #(
   parameter int               ADDR_W     = 16,
   parameter logic [15:0]      WIN_BASE   = 16'h0028,
   parameter int               DW         = 8,
   parameter int               N_BANK     = 4,
   parameter int               ADDR_BYTES = 3,
   parameter int               DATA_BYTES = 2,
   parameter logic [N_BANK-1:0] FULL_MASK = 4'b0101,
   localparam int              SEL_W      = $clog2(N_BANK),
   localparam int              N_SLOT     = 1 + ADDR_BYTES + 2*DATA_BYTES,
   localparam int              SLOT_W     = $clog2(N_SLOT)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              armed,
   input  logic [SEL_W-1:0]                  bank_sel,
   input  logic                              rd_en,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [DW-1:0]                     wdata,
   output logic [DW-1:0]                     rdata,
   output logic [DW-1:0]                     rd_void,
   output logic [N_BANK*DW-1:0]              ctl_q,
   output logic [N_BANK*ADDR_BYTES*DW-1:0]   addr_q,
   output logic [N_BANK*DATA_BYTES*DW-1:0]   data_q,
   output logic [N_BANK*DATA_BYTES*DW-1:0]   mask_q
);
   if (N_SLOT != (1 << SLOT_W)) begin : g_bad_slots
      $error("window slot count must be a power of two");
   end
   if (WIN_BASE % N_SLOT != 0) begin : g_bad_base
      $error("window base must be aligned to the window size");
   end
   if (ADDR_W > 16 || ADDR_W <= SLOT_W) begin : g_bad_aw
      $error("address width out of range");
   end

   logic                 hit;
   logic [SLOT_W-1:0]    slot;
   logic [N_BANK-1:0]    wr_sel;
   logic [N_BANK*DW-1:0] bank_bytes;

   dbg_win_decode #(
      .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .N_BANK(N_BANK),
      .SEL_W(SEL_W), .SLOT_W(SLOT_W)
   ) u_dec (
      .addr(addr), .bank_sel(bank_sel), .wr_en(wr_en), .armed(armed),
      .hit(hit), .slot(slot), .wr_sel(wr_sel)
   );

   for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      dbg_win_bank #(
         .FULL(FULL_MASK[b]), .DW(DW), .ADDR_BYTES(ADDR_BYTES),
         .DATA_BYTES(DATA_BYTES), .SLOT_W(SLOT_W)
      ) u_bank (
         .clk(clk), .rst_n(rst_n), .we(wr_sel[b]), .slot(slot),
         .wdata(wdata),
         .rd_byte(bank_bytes[b*DW +: DW]),
         .ctl_o(ctl_q[b*DW +: DW]),
         .addr_o(addr_q[b*ADDR_BYTES*DW +: ADDR_BYTES*DW]),
         .data_o(data_q[b*DATA_BYTES*DW +: DATA_BYTES*DW]),
         .mask_o(mask_q[b*DATA_BYTES*DW +: DATA_BYTES*DW])
      );
   end

   dbg_win_rdport #(
      .DW(DW), .N_BANK(N_BANK), .SEL_W(SEL_W), .SLOT_W(SLOT_W),
      .ADDR_BYTES(ADDR_BYTES), .FULL_MASK(FULL_MASK)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .hit(hit),
      .bank_sel(bank_sel), .slot(slot), .bank_bytes(bank_bytes),
      .rdata(rdata), .rd_void(rd_void)
   );
endmodule

// File: rtl/dbg_cmp_window_chk.sv
module dbg_cmp_window_chk #(
   parameter int               ADDR_W     = 16,
   parameter logic [15:0]      WIN_BASE   = 16'h0028,
   parameter int               DW         = 8,
   parameter int               N_BANK     = 4,
   parameter int               ADDR_BYTES = 3,
   parameter int               DATA_BYTES = 2,
   parameter logic [N_BANK-1:0] FULL_MASK = 4'b0101,
   parameter int               SEL_W      = 2
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            armed,
   input logic [SEL_W-1:0]                bank_sel,
   input logic                            rd_en,
   input logic                            wr_en,
   input logic [ADDR_W-1:0]               addr,
   input logic [DW-1:0]                   rdata,
   input logic [DW-1:0]                   rd_void,
   input logic [N_BANK*DW-1:0]            ctl_q,
   input logic [N_BANK*ADDR_BYTES*DW-1:0] addr_q,
   input logic [N_BANK*DATA_BYTES*DW-1:0] data_q,
   input logic [N_BANK*DATA_BYTES*DW-1:0] mask_q
);
   localparam int CW = N_BANK*DW + N_BANK*ADDR_BYTES*DW + 2*N_BANK*DATA_BYTES*DW;

   logic          in_win;
   logic          ctl_hit;
   logic [DW-1:0] sel_ctl;
   logic [CW-1:0] all_regs;

   assign in_win   = (addr >= ADDR_W'(WIN_BASE)) && (addr < ADDR_W'(WIN_BASE + 16'd8));
   assign ctl_hit  = in_win && (addr == ADDR_W'(WIN_BASE));
   assign sel_ctl  = ctl_q[bank_sel*DW +: DW];
   assign all_regs = {ctl_q, addr_q, data_q, mask_q};

   // R7
   armed_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> $stable(all_regs));

   // R9
   idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == '0 && rd_void == '0));

   // R2
   outside_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !in_win) |=> (rdata == '0 && rd_void == '1));

   // R10
   same_cycle_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en && ctl_hit) |=> (rdata == $past(sel_ctl)));

   for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      // R3
      unselected_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bank_sel != SEL_W'(b)) |=>
            ($stable(ctl_q[b*DW +: DW]) && $stable(addr_q[b*ADDR_BYTES*DW +: ADDR_BYTES*DW])));
      if (FULL_MASK[b]) begin : g_full
         // R5
         ctl_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_q[b*DW + DW-1] == 1'b0);
      end else begin : g_short
         // R6
         short_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (data_q[b*DATA_BYTES*DW +: DATA_BYTES*DW] == '0) &&
            (mask_q[b*DATA_BYTES*DW +: DATA_BYTES*DW] == '0));
      end
   end
endmodule

bind dbg_cmp_window dbg_cmp_window_chk #(
   .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .DW(DW), .N_BANK(N_BANK),
   .ADDR_BYTES(ADDR_BYTES), .DATA_BYTES(DATA_BYTES),
   .FULL_MASK(FULL_MASK), .SEL_W(SEL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .armed(armed), .bank_sel(bank_sel),
   .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .rdata(rdata),
   .rd_void(rd_void), .ctl_q(ctl_q), .addr_q(addr_q),
   .data_q(data_q), .mask_q(mask_q)
);

// File: tb/dbg_cmp_window_test.sv
`timescale 1ns/1ps
module dbg_cmp_window_test;
   localparam logic [15:0] BASE = 16'h0028;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        armed = 1'b0;
   logic [1:0]  bank_sel = '0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata, rd_void;
   logic [31:0] ctl_q;
   logic [95:0] addr_q;
   logic [63:0] data_q, mask_q;

   int checks = 0;
   int failures = 0;
   bit timeout = 1'b0;

   always #2 clk = ~clk;

   dbg_cmp_window uut (
      .clk(clk), .rst_n(rst_n), .armed(armed), .bank_sel(bank_sel),
      .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rd_void(rd_void), .ctl_q(ctl_q), .addr_q(addr_q),
      .data_q(data_q), .mask_q(mask_q)
   );

   // {bank, offset, write data, expected read, expected void}
   localparam int NV = 10;
   localparam logic [28:0] VECS [NV] = '{
      {2'd0, 3'd0, 8'hFF, 8'h7F, 8'h80},   // R5 comparator 0 ctl top bit
      {2'd0, 3'd1, 8'h12, 8'h12, 8'h00},   // R4 addr high
      {2'd0, 3'd5, 8'h34, 8'h34, 8'h00},   // R4 data low
      {2'd0, 3'd7, 8'h56, 8'h56, 8'h00},   // R4 mask low
      {2'd1, 3'd0, 8'hFF, 8'hFF, 8'h00},   // R5 comparator 1 full ctl
      {2'd1, 3'd4, 8'h99, 8'h00, 8'hFF},   // R6 short bank data
      {2'd2, 3'd2, 8'hAB, 8'hAB, 8'h00},   // R3 comparator 2 addr mid
      {2'd2, 3'd6, 8'hCD, 8'hCD, 8'h00},   // R3 comparator 2 mask high
      {2'd3, 3'd3, 8'hEF, 8'hEF, 8'h00},   // R3 comparator 3 addr low
      {2'd3, 3'd7, 8'h77, 8'h00, 8'hFF}    // R6 short bank mask
   };

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_raw(input logic [1:0] b, input logic [15:0] a, input logic [7:0] d,
                         input logic arm);
      @(negedge clk);
      bank_sel = b; addr = a; wdata = d; wr_en = 1'b1; armed = arm;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_raw(input logic [1:0] b, input logic [15:0] a,
                         output logic [7:0] d, output logic [7:0] v);
      @(negedge clk);
      bank_sel = b; addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata; v = rd_void;
   endtask

   task automatic run_tests();
      logic [7:0] d, v;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 ctl", ctl_q, 0);
      check("R1 addr", addr_q, 0);
      check("R1 data/mask", {data_q, mask_q}, 0);
      check("R1 rdata", {rdata, rd_void}, 0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         wr_raw(VECS[i][28:27], BASE + 16'(VECS[i][26:24]), VECS[i][23:16], 1'b0);
         rd_raw(VECS[i][28:27], BASE + 16'(VECS[i][26:24]), d, v);
         check($sformatf("R4 vec%0d rdata", i), d, VECS[i][15:8]);
         check($sformatf("R5/R6 vec%0d rd_void", i), v, VECS[i][7:0]);
      end

      // R3 only the selected bank took each write
      check("R3 ctl_q", ctl_q, 32'h0000_FF7F);
      check("R3 addr_q", addr_q, {24'h0000EF, 24'h00AB00, 24'h000000, 24'h120000});
      check("R6 data_q", data_q, 64'h0000_0000_0000_0034);
      check("R6 mask_q", mask_q, 64'h0000_CD00_0000_0056);

      // R9 idle cycle after a read returns zero
      rd_raw(2'd0, BASE + 16'd1, d, v);
      @(negedge clk);
      check("R9 idle rdata", {rdata, rd_void}, 0);

      // R2 outside window: write dropped, read void
      wr_raw(2'd0, 16'h0030, 8'h5A, 1'b0);
      wr_raw(2'd0, 16'h0027, 8'h5A, 1'b0);
      check("R2 regs unchanged", {ctl_q, addr_q}, {32'h0000_FF7F, 24'h0000EF, 24'h00AB00, 24'h000000, 24'h120000});
      rd_raw(2'd0, 16'h0030, d, v);
      check("R2 read outside", {d, v}, 16'h00FF);

      // R7 armed raised with the write strobe; R8 read while armed
      wr_raw(2'd0, BASE + 16'd1, 8'h00, 1'b1);
      wr_raw(2'd1, BASE, 8'h00, 1'b1);
      rd_raw(2'd0, BASE + 16'd1, d, v);
      check("R8 read while armed", d, 8'h12);
      check("R7 ctl unchanged", ctl_q, 32'h0000_FF7F);
      @(negedge clk);
      armed = 1'b0;

      // R10 read and write to the same register in one cycle
      @(negedge clk);
      bank_sel = 2'd0; addr = BASE + 16'd1; wdata = 8'h5A; wr_en = 1'b1; rd_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      check("R10 old value", rdata, 8'h12);
      rd_raw(2'd0, BASE + 16'd1, d, v);
      check("R10 new value", d, 8'h5A);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (100000) @(posedge clk);
            timeout = 1'b1;
         end
      join_any
      if (timeout) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule